// File: doc/BRIEF.md
# Signed High-Word Multiply-Accumulate Unit

This datapath takes two signed operands of `WIDTH` bits, forms their full double-width product, and returns only the upper half of the result. Before that upper half is taken, an optional third operand can be placed in the upper half of a double-width value and the product added to it or subtracted from it. A rounding switch adds half of one unit of the upper word ahead of the extraction. Without rounding, the lower half is simply dropped.

Each request is presented for one cycle with a valid strobe. The answer appears on a registered output exactly one clock later, with its own valid flag. The unit drives no status or condition outputs of any kind. Overflow of the upper word wraps silently.

Top module: `hiw_mac`

## Requirements
- R1: With `mode` = 2'b00 and `rnd` = 0, `res` equals floor(a*b / 2^WIDTH) mod 2^WIDTH, with `a` and `b` read as two's complement numbers.
- R2: With `rnd` = 1, the constant 2^(WIDTH-1) is added to the double-width value before its upper WIDTH bits are taken, in every mode.
- R3: With `mode` = 2'b01, `res` equals ((acc << WIDTH) + a*b + k)[2*WIDTH-1:WIDTH], where k is the rounding constant or zero.
- R4: With `mode` = 2'b10, `res` equals ((acc << WIDTH) - a*b + k)[2*WIDTH-1:WIDTH].
- R5: `mode` = 2'b11 gives the same result as 2'b00, and `acc` has no effect on it.
- R6: A carry or borrow out of the top bit is discarded, so the upper word wraps modulo 2^WIDTH.
- R7: `res` and `res_vld` update one clock after a cycle with `in_vld` high. `res_vld` is high exactly in the cycle after an accepted request.
- R8: In a cycle after `in_vld` was low, `res_vld` is low and `res` keeps its previous value, whatever the other inputs were.
- R9: A synchronous active-high `rst` clears `res_vld` and `res` to zero at the next clock edge, even if `in_vld` is high.
- R10: With `mode` = 2'b00, the value on `acc` has no effect on `res`.
- R11: The most negative value times itself with `acc` = 0 gives 2^(WIDTH-2) (0x40000000 at 32 bits) in modes 2'b00, 2'b01 and 2'b11 with either rounding setting. Mode 2'b10 gives its negation (0xC0000000).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Request strobe |
| a | input | WIDTH | First signed multiplicand |
| b | input | WIDTH | Second signed multiplicand |
| acc | input | WIDTH | Accumulator operand, placed in the upper half |
| mode | input | 2 | 00 multiply, 01 accumulate, 10 subtract, 11 treated as multiply |
| rnd | input | 1 | 1 rounds, 0 truncates |
| res_vld | output | 1 | Result valid, one cycle after `in_vld` |
| res | output | WIDTH | Registered upper word of the result |

## Verification
An 8-bit copy is swept over every operand pair in plain multiply. This catches an unsigned multiply or a product that is not sign-extended, both of which give wrong upper words for negative inputs. A strided sweep across all modes, both rounding settings and varied accumulator values catches three faults:
- rounding applied after extraction instead of before, which misses the carry from the low half;
- subtraction done in the wrong order;
- the reserved code leaking the accumulator.

At 32 bits, directed cases cover three further points:
- the most-negative-squared corner, where a narrow product would overflow its sign;
- wrapping past the largest positive word;
- −1 × 1 under rounding, which must give 0 rather than all ones.

Idle cycles and a reset asserted while a request is pending show whether the output register loads when it should not.

// File: rtl/hiw_mac_pkg.sv
package hiw_mac_pkg;
  typedef enum logic [1:0] {
    MODE_MUL = 2'b00,
    MODE_ADD = 2'b01,
    MODE_SUB = 2'b10,
    MODE_RSV = 2'b11
  } mode_e;
endpackage

// File: rtl/hiw_mult.sv
module hiw_mult #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0]   a,
  input  logic [WIDTH-1:0]   b,
  output logic [2*WIDTH-1:0] prod
);
  localparam int PW = 2 * WIDTH;

  logic [PW-1:0] a_x;
  logic [PW-1:0] b_x;

  assign a_x  = {{WIDTH{a[WIDTH-1]}}, a};
  assign b_x  = {{WIDTH{b[WIDTH-1]}}, b};
  assign prod = a_x * b_x;

  always_comb begin
    if (a != '0 && b != '0) begin
      // R1
      prod_sign_chk: assert (prod[PW-1] == (a[WIDTH-1] ^ b[WIDTH-1]))
        else $error("signed product has wrong sign");
    end
  end
endmodule

// File: rtl/hiw_comb.sv
module hiw_comb
  import hiw_mac_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [2*WIDTH-1:0] prod,
  input  logic [WIDTH-1:0]   acc,
  input  logic [1:0]         mode,
  input  logic               rnd,
  output logic [WIDTH-1:0]   hi
);
  localparam int PW = 2 * WIDTH;
  localparam logic [PW-1:0] RND_K = {{WIDTH{1'b0}}, 1'b1, {(WIDTH-1){1'b0}}};

  mode_e         m;
  logic [PW-1:0] base;
  logic [PW-1:0] kval;
  logic [PW-1:0] sum;

  assign m    = mode_e'(mode);
  assign kval = rnd ? RND_K : '0;

  always_comb begin
    case (m)
      MODE_ADD, MODE_SUB: base = {acc, {WIDTH{1'b0}}};
      default:            base = '0;
    endcase
    if (m == MODE_SUB) sum = base - prod + kval;
    else               sum = base + prod + kval;
  end

  assign hi = sum[PW-1:WIDTH];
endmodule

// File: rtl/hiw_outreg.sv
module hiw_outreg #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic [WIDTH-1:0] d,
  output logic             q_vld,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_vld <= 1'b0;
      q     <= '0;
    end else begin
      q_vld <= ld;
      if (ld) q <= d;
    end
  end

  // R7
  vld_rise_chk: assert property (@(posedge clk) disable iff (rst) ld |=> q_vld);
  // R7
  vld_idle_chk: assert property (@(posedge clk) disable iff (rst) !ld |=> !q_vld);
  // R8
  hold_word_chk: assert property (@(posedge clk) disable iff (rst) !ld |=> $stable(q));
  // R9
  rst_clear_chk: assert property (@(posedge clk) rst |=> (!q_vld && q == '0));
endmodule

// File: rtl/hiw_mac.sv
module hiw_mac
  import hiw_mac_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [WIDTH-1:0] acc,
  input  logic [1:0]       mode,
  input  logic             rnd,
  output logic             res_vld,
  output logic [WIDTH-1:0] res
);
  localparam int PW = 2 * WIDTH;
  localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic [WIDTH-1:0] QUARTER  = {2'b01, {(WIDTH-2){1'b0}}};

  logic [PW-1:0]    prod;
  logic [WIDTH-1:0] hi;

  hiw_mult #(.WIDTH(WIDTH)) u_mult (
    .a    (a),
    .b    (b),
    .prod (prod)
  );

  hiw_comb #(.WIDTH(WIDTH)) u_comb (
    .prod (prod),
    .acc  (acc),
    .mode (mode),
    .rnd  (rnd),
    .hi   (hi)
  );

  hiw_outreg #(.WIDTH(WIDTH)) u_oreg (
    .clk   (clk),
    .rst   (rst),
    .ld    (in_vld),
    .d     (hi),
    .q_vld (res_vld),
    .q     (res)
  );

  // R11
  neg_square_chk: assert property (@(posedge clk) disable iff (rst)
    (in_vld && a == MOST_NEG && b == MOST_NEG && acc == '0 && mode != MODE_SUB)
      |=> (res == QUARTER));
endmodule

// File: tb/hiw_mac_bench.sv
module hiw_mac_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WS = 8;
  localparam int WL = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  logic          s_vld = 1'b0, s_rnd = 1'b0;
  logic [WS-1:0] s_a = '0, s_b = '0, s_acc = '0;
  logic [1:0]    s_mode = 2'b00;
  logic          s_ov;
  logic [WS-1:0] s_res;

  logic          l_vld = 1'b0, l_rnd = 1'b0;
  logic [WL-1:0] l_a = '0, l_b = '0, l_acc = '0;
  logic [1:0]    l_mode = 2'b00;
  logic          l_ov;
  logic [WL-1:0] l_res;

  hiw_mac #(.WIDTH(WS)) u_hiw_mac (
    .clk(clk), .rst(rst), .in_vld(s_vld), .a(s_a), .b(s_b), .acc(s_acc),
    .mode(s_mode), .rnd(s_rnd), .res_vld(s_ov), .res(s_res)
  );

  hiw_mac #(.WIDTH(WL)) u_hiw_mac_wide (
    .clk(clk), .rst(rst), .in_vld(l_vld), .a(l_a), .b(l_b), .acc(l_acc),
    .mode(l_mode), .rnd(l_rnd), .res_vld(l_ov), .res(l_res)
  );

  function automatic longint model(int w, longint a, longint b, longint acc,
                                   int mode, bit rnd);
    longint msk, sgn, as, bs, base, sum;
    msk  = (w == 64) ? -1 : ((longint'(1) << w) - 1);
    sgn  = longint'(1) << (w - 1);
    as   = ((a & msk) ^ sgn) - sgn;
    bs   = ((b & msk) ^ sgn) - sgn;
    base = (mode == 1 || mode == 2) ? ((acc & msk) << w) : 0;
    if (mode == 2) sum = base - as * bs;
    else           sum = base + as * bs;
    if (rnd) sum = sum + sgn;
    return (sum >> w) & msk;
  endfunction

  task automatic check(string tag, longint got, longint exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  function automatic string tag_of(int mode, bit rnd, bit wide_acc);
    if (rnd)       return "R2";
    if (mode == 1) return wide_acc ? "R6" : "R3";
    if (mode == 2) return "R4";
    if (mode == 3) return "R5";
    return "R10";
  endfunction

  task automatic go_s(int a, int b, int acc, int mode, bit rnd, string tag);
    @(negedge clk);
    s_vld = 1'b1; s_a = WS'(a); s_b = WS'(b); s_acc = WS'(acc);
    s_mode = 2'(mode); s_rnd = rnd;
    @(posedge clk); #1;
    check(tag, longint'(s_res), model(WS, a, b, acc, mode, rnd));
  endtask

  task automatic go_l(longint a, longint b, longint acc, int mode, bit rnd,
                      string tag);
    @(negedge clk);
    l_vld = 1'b1; l_a = WL'(a); l_b = WL'(b); l_acc = WL'(acc);
    l_mode = 2'(mode); l_rnd = rnd;
    @(posedge clk); #1;
    check(tag, longint'(l_res), model(WL, a, b, acc, mode, rnd));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [WL-1:0] held;
    repeat (3) @(posedge clk);
    #1;
    check("R9", {s_ov, l_ov}, 0);
    check("R9", longint'(s_res) + longint'(l_res), 0);
    @(negedge clk);
    rst = 1'b0;

    // R1: every operand pair at 8 bits, plain multiply, truncating
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        go_s(a, b, (a + b) & 255, 0, 1'b0, "R1");
    check("R7", s_ov, 1);

    // R2 R3 R4 R5 R6 R10: strided sweep over modes and rounding
    for (int m = 0; m < 4; m++)
      for (int r = 0; r < 2; r++)
        for (int a = 0; a < 256; a += 5)
          for (int b = 0; b < 256; b += 7)
            go_s(a, b, (a * 3 + b * 11) & 255, m, r[0],
                 tag_of(m, r[0], ((a * 3 + b * 11) & 255) > 120));

    // R11 and wide directed cases
    for (int m = 0; m < 4; m++)
      for (int r = 0; r < 2; r++) begin
        go_l(32'h8000_0000, 32'h8000_0000, 0, m, r[0], "R11");
        check("R11", longint'(l_res), (m == 2) ? 32'hC000_0000 : 32'h4000_0000);
      end
    go_l(32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, 0, 1'b0, "R1");
    go_l(32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, 0, 1'b1, "R2");
    go_l(32'hFFFF_FFFF, 1, 0, 0, 1'b0, "R1");
    check("R1", longint'(l_res), 32'hFFFF_FFFF);
    go_l(32'hFFFF_FFFF, 1, 0, 0, 1'b1, "R2");
    check("R2", longint'(l_res), 0);
    go_l(32'h4000_0000, 32'h4000_0000, 32'h7FFF_FFFF, 1, 1'b0, "R6");
    check("R6", longint'(l_res), 32'h8FFF_FFFF);
    go_l(32'h4000_0000, 32'h4000_0000, 32'h8000_0000, 2, 1'b0, "R6");
    check("R6", longint'(l_res), 32'h7000_0000);
    go_l(32'h1234_5678, 32'h9ABC_DEF0, 32'h5555_AAAA, 3, 1'b0, "R5");
    go_l(32'h1234_5678, 32'h9ABC_DEF0, 32'h5555_AAAA, 0, 1'b1, "R10");
    go_l(32'hDEAD_BEEF, 32'h0BAD_F00D, 32'h0000_1234, 2, 1'b1, "R4");

    // R7: inputs changed but no edge yet, output still holds old value
    held = l_res;
    @(negedge clk);
    l_a = 32'h0000_0100; l_b = 32'h0100_0000; l_mode = 2'b00; l_rnd = 1'b0;
    #1;
    check("R7", longint'(l_res), longint'(held));
    @(posedge clk); #1;
    check("R7", longint'(l_res), 1);
    check("R7", l_ov, 1);

    // R8: idle cycle with new inputs leaves result unchanged
    held = l_res;
    @(negedge clk);
    l_vld = 1'b0; s_vld = 1'b0;
    l_a = 32'h7FFF_0000; l_b = 32'h7FFF_0000; l_acc = 32'h1111_1111;
    @(posedge clk); #1;
    check("R8", longint'(l_res), longint'(held));
    check("R8", l_ov, 0);
    check("R8", s_ov, 0);

    // R9: reset wins over a pending request
    @(negedge clk);
    l_vld = 1'b1; s_vld = 1'b1; rst = 1'b1;
    @(posedge clk); #1;
    check("R9", l_ov, 0);
    check("R9", longint'(l_res), 0);
    @(negedge clk);
    rst = 1'b0; l_vld = 1'b0; s_vld = 1'b0;
    @(posedge clk); #1;

    done = 1'b1;
    summary();
    $finish;
  end
endmodule